// File: doc/BRIEF.md
# Serial I/O Write Requester

This block carries out an I/O write of any byte length starting at any byte address. It takes one command (start address, byte count, timeout limit) and splits it into a chain of non-posted I/O write requests. Each request covers only the bytes that remain inside the current 32-bit word. At most one request is in flight at any time. Before each request the block takes a tag from a small pool. It then presents the request header and waits for a completion that carries the same tag. A successful completion moves the address and the consumed count forward and starts the next request.

A completion with a failing status ends the transfer with a one-cycle error pulse. So does a wait that lasts longer than the programmed number of cycles. The tag of a request that timed out is held back until its late completion turns up, so that tag is not reused while an answer may still arrive. The write data is not held here: each request reports its byte offset into the caller's buffer, and the surrounding logic fetches the payload itself.

Top module: `iowr_requester`

## Requirements
- R1: `cmd_ready` is high only when the block is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A command with length 0 sends no request, and `done` is high in the cycle that follows acceptance.
- R2: Each request's `req_bytes` equals the smaller of the remaining length and 4 − (`req_addr` mod 4). `req_addr` starts at the command address. `req_offset` starts at 0. Both grow by `req_bytes` after each successful completion.
- R3: In `req_be`, bit i stands for byte lane i of the addressed word. Exactly the bits from `req_addr[1:0]` up to `req_addr[1:0]` + `req_bytes` − 1 are set.
- R4: Every request carries `req_kind` = 8'h42 (I/O write, three-dword header with data) and `req_rid` = 16'h0000 (bus 0, device 0, function 0).
- R5: Each request takes the lowest-numbered free tag from a pool of `NUM_TAGS` tags. While no tag is free, no request is presented.
- R6: After a request is accepted, no new request is presented until a completion arrives whose `cpl_tag` matches that request's tag. A completion with any other tag does not advance the transfer.
- R7: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged.
- R8: A matching completion whose 3-bit `cpl_status` is not 3'b000 ends the transfer. `error` is high in the next cycle and the tag becomes free.
- R9: If the command's timeout T is not zero and no matching completion has arrived in the T cycles after a request was accepted, `error` is high in the cycle after the T-th cycle. A completion in the T-th cycle is still accepted. T = 0 disables the timeout. A timed-out tag stays taken until a completion with its tag arrives, in any state.
- R10: `done` goes high for one cycle, in the cycle after the successful completion of the last request. `done` and `error` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | First byte address |
| cmd_len | input | LEN_W | Byte count of the transfer |
| cmd_timeout | input | TO_W | Completion wait limit in cycles, 0 = none |
| req_valid | output | 1 | Request header present |
| req_ready | input | 1 | Request header taken |
| req_addr | output | ADDR_W | Byte address of this request |
| req_be | output | 4 | Byte enables for the addressed word |
| req_bytes | output | 3 | Bytes carried by this request, 1 to 4 |
| req_offset | output | LEN_W | Offset of this request's first byte in the source buffer |
| req_tag | output | TAG_W | Tag of this request |
| req_kind | output | 8 | Request format and type code |
| req_rid | output | 16 | Requester identifier |
| cpl_valid | input | 1 | Completion present for one cycle |
| cpl_tag | input | TAG_W | Tag of the completion |
| cpl_status | input | 3 | Completion status, 3'b000 = success |
| done | output | 1 | Transfer finished successfully (pulse) |
| error | output | 1 | Transfer aborted (pulse) |

## Verification
The assertions check, on every cycle, that a stalled request keeps its fields and that the byte enables agree with the byte count and never cross a word boundary. They also check that the wait does not end while no completion or timeout is present, that the timeout never fires with a zero limit, that done and error stay exclusive one-cycle pulses, and that the pool hands out only free tags. The following can only be shown by the bench's scenarios: the exact splitting of a transfer into requests for a given address and length, the lowest-free tag order, the stall while every tag is quarantined and its release by a late completion, the exact cycle at which a timeout fires, and the abort on a failing status partway through a transfer.

// File: rtl/iowr_pkg.sv
package iowr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALLOC,
        ST_SEND,
        ST_WAIT,
        ST_DONE,
        ST_ERROR
    } iowr_state_e;

    localparam logic [2:0]  CPL_SUCCESS = 3'b000;
    localparam logic [7:0]  IO_WRITE_KIND = 8'h42;
    localparam logic [15:0] HOST_REQ_ID = 16'h0000;

endpackage

// File: rtl/iowr_split.sv
// Sizes one request so that it stays inside a single 32-bit word.
module iowr_split #(
    parameter int LEN_W = 16
) (
    input  logic [1:0]       lane,
    input  logic [LEN_W-1:0] remaining,
    output logic [2:0]       nbytes,
    output logic [3:0]       be
);
    logic [2:0] room;
    logic [4:0] mask;

    always_comb begin
        room   = 3'd4 - {1'b0, lane};
        nbytes = (remaining < LEN_W'(room)) ? remaining[2:0] : room;
        mask   = (5'd1 << nbytes) - 5'd1;
        be     = 4'(mask[3:0] << lane);
    end
endmodule

// File: rtl/iowr_tag_pool.sv
// Free-bit vector of tags; hands out the lowest free one.
module iowr_tag_pool #(
    parameter int NUM_TAGS = 4,
    parameter int TAG_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             any_free,
    input  logic             rel_en,
    input  logic [TAG_W-1:0] rel_tag
);
    logic [NUM_TAGS-1:0] free_d, free_q;
    logic                rel_ok;

    always_comb begin
        any_free  = |free_q;
        alloc_tag = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_tag = TAG_W'(i);
        end
        rel_ok = rel_en && (int'(rel_tag) < NUM_TAGS) && !free_q[rel_tag];
        free_d = free_q;
        if (alloc_en && any_free) free_d[alloc_tag] = 1'b0;
        if (rel_ok) free_d[rel_tag] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= free_d;
    end

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> any_free && free_q[alloc_tag]); // R5

    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ok |=> free_q[$past(rel_tag)]); // R9
endmodule

// File: rtl/iowr_timer.sv
// Counts wait cycles; flags the last allowed cycle of a nonzero limit.
module iowr_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (limit != '0) && (cnt_q == limit - TO_W'(1));
        cnt_d   = cnt_q;
        if (clear)                cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + TO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/iowr_requester.sv
module iowr_requester
    import iowr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int TO_W     = 16,
    parameter int NUM_TAGS = 4,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TO_W-1:0]   cmd_timeout,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [3:0]        req_be,
    output logic [2:0]        req_bytes,
    output logic [LEN_W-1:0]  req_offset,
    output logic [TAG_W-1:0]  req_tag,
    output logic [7:0]        req_kind,
    output logic [15:0]       req_rid,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [2:0]        cpl_status,
    output logic              done,
    output logic              error
);
    typedef struct packed {
        iowr_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  off;
        logic [TO_W-1:0]   limit;
        logic [TAG_W-1:0]  tag;
    } regs_t;

    regs_t            r_d, r_q;
    logic [2:0]       nbytes;
    logic [3:0]       be;
    logic             alloc_en, any_free;
    logic [TAG_W-1:0] alloc_tag;
    logic             tmr_clear, tmr_run, expired;
    logic             cpl_hit;

    iowr_split #(.LEN_W(LEN_W)) u_split (
        .lane      (r_q.addr[1:0]),
        .remaining (r_q.rem),
        .nbytes    (nbytes),
        .be        (be)
    );

    iowr_tag_pool #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_tag (alloc_tag),
        .any_free  (any_free),
        .rel_en    (cpl_valid),
        .rel_tag   (cpl_tag)
    );

    iowr_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .limit   (r_q.limit),
        .expired (expired)
    );

    always_comb begin
        r_d       = r_q;
        alloc_en  = 1'b0;
        tmr_clear = (r_q.st == ST_SEND);
        tmr_run   = (r_q.st == ST_WAIT);
        cpl_hit   = cpl_valid && (r_q.st == ST_WAIT) && (cpl_tag == r_q.tag);
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr  = cmd_addr;
                    r_d.rem   = cmd_len;
                    r_d.off   = '0;
                    r_d.limit = cmd_timeout;
                    r_d.st    = (cmd_len == '0) ? ST_DONE : ST_ALLOC;
                end
            end
            ST_ALLOC: begin
                if (any_free) begin
                    alloc_en = 1'b1;
                    r_d.tag  = alloc_tag;
                    r_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (cpl_hit) begin
                    if (cpl_status == CPL_SUCCESS) begin
                        r_d.addr = r_q.addr + ADDR_W'(nbytes);
                        r_d.rem  = r_q.rem - LEN_W'(nbytes);
                        r_d.off  = r_q.off + LEN_W'(nbytes);
                        r_d.st   = (r_q.rem == LEN_W'(nbytes)) ? ST_DONE : ST_ALLOC;
                    end else begin
                        r_d.st = ST_ERROR;
                    end
                end else if (expired) begin
                    r_d.st = ST_ERROR;
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            ST_ERROR: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.rem   <= '0;
            r_q.off   <= '0;
            r_q.limit <= '0;
            r_q.tag   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.st == ST_IDLE);
    assign req_valid  = (r_q.st == ST_SEND);
    assign req_addr   = r_q.addr;
    assign req_be     = be;
    assign req_bytes  = nbytes;
    assign req_offset = r_q.off;
    assign req_tag    = r_q.tag;
    assign req_kind   = IO_WRITE_KIND;
    assign req_rid    = HOST_REQ_ID;
    assign done       = (r_q.st == ST_DONE);
    assign error      = (r_q.st == ST_ERROR);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_tag) && $stable(req_offset)); // R7

    AST_BE_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_be) == int'(req_bytes)) && (req_be[req_addr[1:0]] == 1'b1)); // R3

    AST_NO_LANE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({2'b00, req_addr[1:0]} + {1'b0, req_bytes}) <= 4'd4); // R2

    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) && !cpl_hit && !expired |=> (r_q.st == ST_WAIT) && !req_valid); // R6

    AST_NO_TIMEOUT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) && !cpl_valid && (r_q.limit == '0) |=> !error); // R9

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10

    AST_PULSES_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        done || error |=> !done && !error); // R10
endmodule

// File: tb/iowr_requester_test.sv
module iowr_requester_test;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic [15:0] cmd_timeout = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [3:0]  req_be;
    logic [2:0]  req_bytes;
    logic [15:0] req_offset;
    logic [1:0]  req_tag;
    logic [7:0]  req_kind;
    logic [15:0] req_rid;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_tag = '0;
    logic [2:0]  cpl_status = '0;
    logic        done, error;

    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          busy [NT];
    int          last_tag = 0;

    iowr_requester #(.NUM_TAGS(NT)) uut (.*);

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
                $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_bytes(input logic [31:0] a, input int rem);
        int room = 4 - int'(a[1:0]);
        return (rem < room) ? rem : room;
    endfunction

    function automatic logic [3:0] exp_be(input logic [31:0] a, input int n);
        return 4'(((1 << n) - 1) << a[1:0]);
    endfunction

    function automatic int lowest_free();
        for (int i = 0; i < NT; i++) if (!busy[i]) return i;
        return -1;
    endfunction

    task automatic send_cpl(input int tag, input logic [2:0] st);
        cpl_valid  = 1'b1;
        cpl_tag    = 2'(tag);
        cpl_status = st;
        @(negedge clk);
        cpl_valid = 1'b0;
        busy[tag] = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a, input int len, input int to);
        chk(cmd_ready == 1'b1, "R1 ready when idle", cmd_ready, 1);
        cmd_addr = a; cmd_len = 16'(len); cmd_timeout = 16'(to);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // fkind: 0 all succeed, 1 failing status at request fidx, 2 no completion at fidx
    task automatic do_xfer(input logic [31:0] addr, input int len, input int to,
                           input int fkind, input int fidx, input int dly);
        logic [31:0] a = addr;
        int rem = len, off = 0, k = 0, g, nb, et, d, stray;
        logic [2:0] st;
        issue(addr, len, to);
        if (len == 0) begin
            chk(done == 1'b1 && req_valid == 1'b0, "R1 zero length done", done, 1);
            @(negedge clk);
            return;
        end
        while (rem > 0) begin
            g = 0;
            while (!req_valid && g < 200) begin
                if (g == 0) chk(cmd_ready == 1'b0, "R1 busy not ready", cmd_ready, 0);
                @(negedge clk); g++;
            end
            if (!req_valid) begin
                chk(1'b0, "R5 request missing", 0, 1);
                return;
            end
            et = lowest_free();
            nb = exp_bytes(a, rem);
            chk(req_addr == a, "R2 address", req_addr, a);
            chk(int'(req_bytes) == nb, "R2 byte count", req_bytes, nb);
            chk(int'(req_offset) == off, "R2 offset", req_offset, off);
            chk(req_be == exp_be(a, nb), "R3 byte enables", req_be, exp_be(a, nb));
            chk(req_kind == 8'h42 && req_rid == 16'h0, "R4 kind and id", {req_kind, req_rid}, 24'h420000);
            chk(int'(req_tag) == et, "R5 lowest free tag", req_tag, et);
            busy[et] = 1'b1;
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(req_valid && req_addr == a && int'(req_tag) == et && req_be == exp_be(a, nb),
                    "R7 held while stalled", req_addr, a);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid == 1'b0, "R6 one outstanding", req_valid, 0);
            if (fkind == 2 && k == fidx) begin
                repeat (to - 1) begin
                    @(negedge clk);
                    chk(error == 1'b0 && req_valid == 1'b0, "R9 before limit", error, 0);
                end
                @(negedge clk);
                chk(error == 1'b1, "R9 timeout error", error, 1);
                last_tag = et;
                @(negedge clk);
                return;
            end
            if (dly < 0) begin
                stray = $urandom % 2;
                if (stray != 0) begin
                    send_cpl((et + 1) % NT, 3'($urandom % 8));
                    chk(req_valid == 1'b0 && error == 1'b0 && done == 1'b0,
                        "R6 foreign tag ignored", {req_valid, error, done}, 0);
                end
                d = $urandom % 3;
            end else begin
                d = dly;
            end
            repeat (d) begin
                @(negedge clk);
                chk(req_valid == 1'b0 && error == 1'b0, "R6 waits for completion", req_valid, 0);
            end
            st = (fkind == 1 && k == fidx) ? 3'(1 + $urandom % 7) : 3'b000;
            send_cpl(et, st);
            if (st != 3'b000) begin
                chk(error == 1'b1 && done == 1'b0, "R8 bad status aborts", error, 1);
                @(negedge clk);
                chk(error == 1'b0 && cmd_ready == 1'b1, "R8 back to idle", error, 0);
                return;
            end
            rem -= nb; a += 32'(nb); off += nb; k++;
            if (rem == 0) chk(done == 1'b1 && error == 1'b0, "R10 done after last", done, 1);
            else          chk(done == 1'b0 && error == 1'b0, "R10 no early done", done, 0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NT; i++) busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0 && error == 1'b0,
            "R1 reset state", {cmd_ready, req_valid, done, error}, 4'b1000);

        do_xfer(32'h100, 0, 0, 0, 0, -1);        // R1 zero length
        do_xfer(32'h203, 1, 0, 0, 0, -1);        // R2 last lane only
        do_xfer(32'h301, 7, 0, 0, 0, -1);        // R2 3 then 4 bytes
        do_xfer(32'h400, 9, 20, 0, 0, -1);       // R2 aligned with tail
        do_xfer(32'h502, 10, 0, 1, 2, -1);       // R8 mid transfer
        do_xfer(32'h600, 4, 6, 0, 0, 5);         // R9 completion in last allowed cycle
        do_xfer(32'h700, 2, 0, 0, 0, 60);        // R9 zero disables timeout
        do_xfer(32'h800, 6, 5, 2, 1, -1);        // R9 timeout on second request
        chk(busy[last_tag] == 1'b1, "R9 tag quarantined", busy[last_tag], 1);
        do_xfer(32'h900, 3, 0, 0, 0, -1);        // R5 skips quarantined tag
        send_cpl(last_tag, 3'b000);              // R9 late completion frees it

        // R5 exhaustion: quarantine every tag, then free one
        for (int t = 0; t < NT; t++) do_xfer(32'hA00 + 32'(t), 4, 4, 2, 0, -1);
        issue(32'hB00, 4, 0);
        repeat (10) begin
            @(negedge clk);
            chk(req_valid == 1'b0, "R5 stall with no tag", req_valid, 0);
        end
        send_cpl(2, 3'b000);
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b1 && req_tag == 2'd2, "R5 freed tag used", req_tag, 2);
        busy[2] = 1'b1;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        send_cpl(2, 3'b000);
        chk(done == 1'b1, "R10 done after stall", done, 1);
        @(negedge clk);
        send_cpl(0, 3'b000);
        send_cpl(1, 3'b000);
        send_cpl(3, 3'b000);

        for (int n = 0; n < 80; n++) begin
            int len = $urandom % 13;
            int kind = $urandom % 10;
            logic [31:0] a = $urandom;
            if (kind == 0)      do_xfer(a, len, 0, 1, $urandom % 4, -1);
            else if (kind == 1) begin
                do_xfer(a, len, 8, 2, $urandom % 4, -1);
                if (busy[last_tag]) send_cpl(last_tag, 3'b000);
            end
            else                do_xfer(a, len, (kind > 5) ? 20 : 0, 0, 0, -1);
            @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule